// File: doc/BRIEF.md
# Super-Block Reuse-Based Allocation Filter

This block makes the allocation decision for a set-associative last-level cache whose tags name super-blocks of four contiguous memory blocks rather than single blocks. Every tag entry carries a validity bit per member block. A lookup reports whether the requested block is resident. On a miss, the block decides whether to store the block or to pass it to the requester without storing it, and it names the way that the data array should use.

The filter targets uncompressed blocks that arrive for a super-block that already owns a tag in the set. The first such miss is bypassed, and a per-block "seen" bit in the shared tag records it. If the same block misses again while that tag survives, it is stored. Blocks of super-blocks that have no tag in the set are allocated as in an ordinary cache, with the victim taken from a separate true-LRU replacement unit. Requests flagged as compressed skip the filter and always allocate. The outcome is registered and appears one cycle after the request, and the tag state is updated on the same edge, so the next request sees the new state.

Top module: `sb_alloc_filter`

## Requirements
- R1: The block address is split as follows. Bits [1:0] pick the block inside its super-block. The next log2(NUM_SETS) bits pick the set. The remaining upper bits form the super-block tag. A request whose super-block tag is present in the set with that block's valid bit set reports hit with the matching way.
- R2: Whenever rspValid is high, exactly one of rspHit, rspAlloc and rspBypass is high. When rspValid is low, all three are low.
- R3: A miss whose super-block has no tag in the set allocates a new tag. It uses the lowest-numbered way with no valid block and, when the set is full, the least recently used way.
- R4: An uncompressed miss on a super-block that is present in the set, with that block's seen bit clear, reports bypass with the matching way. The block is not stored: a repeat of the request does not hit.
- R5: An uncompressed miss on a present super-block with the block's seen bit set allocates the block into the matching way and clears the seen bit. A following request for the block hits. Other accesses in between do not disturb the seen bit.
- R6: A compressed request (reqUncomp low) is never bypassed. A compressed miss on a present super-block allocates at once into the matching way.
- R7: Evicting a super-block tag discards its seen bits. After the super-block is installed again, an uncompressed miss on a previously seen sibling block is bypassed once more.
- R8: Hits and allocations make their way the most recently used in the set. Bypasses leave the recency order unchanged. Sets keep independent state.
- R9: During reset rspValid is low. After reset all sets are empty, so the first allocation in any set uses way 0.
- R10: Each accepted request (reqValid high at a clock edge) yields exactly one response, with rspValid high, on the following edge. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present this cycle |
| reqAddr | input | ADDR_W | Block address of the request |
| reqUncomp | input | 1 | High when the requested block is uncompressed |
| rspValid | output | 1 | Response for the request of the previous cycle |
| rspHit | output | 1 | Requested block was resident |
| rspAlloc | output | 1 | Block is stored in way rspWay |
| rspBypass | output | 1 | Block is not stored; first use of a partly resident super-block |
| rspWay | output | log2(NUM_WAYS) | Matching way on hit or bypass, target way on allocation |

## Verification
The hardest case to reach from the ports is the loss of a seen bit through eviction. Reaching it takes a bypass, then enough new super-blocks in the same set to make the owning tag the LRU victim, then a re-install of the same super-block before the sibling is touched again. The stimulus fills one set with four super-blocks and steers the recency order with chosen hits and allocations. It inserts a bypass that must not refresh its way, and only then forces the eviction. As a result, the victim way numbers themselves check both R8 and R7.

// File: rtl/sbaf_pkg.sv
package sbaf_pkg;

  localparam int SB_BLOCKS = 4;
  localparam int SB_OFF_W  = 2;

  // Strobes from the decision logic to the tag store
  typedef struct packed {
    logic tagWrite;   // install a new super-block tag in wrWay
    logic validSet;   // mark requested block valid in wrWay
    logic seenSet;    // record a bypassed first use
    logic seenClr;    // forget the first use after allocating
    logic lruTouch;   // refresh recency of wrWay
  } sbafStrobe_t;

  // Lookup status from the tag store
  typedef struct packed {
    logic sbPresent;  // super-block tag matches in the set
    logic blkValid;   // requested block valid under that tag
    logic blkSeen;    // requested block bypassed once before
    logic freeAny;    // set holds a way with no valid block
  } sbafLookup_t;

  typedef enum logic [1:0] {
    OUT_NONE   = 2'd0,
    OUT_HIT    = 2'd1,
    OUT_ALLOC  = 2'd2,
    OUT_BYPASS = 2'd3
  } sbafOutcome_t;

endpackage

// File: rtl/sbaf_lru.sv
module sbaf_lru #(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] setIdx,
  input  logic             touchEn,
  input  logic [WAY_W-1:0] touchWay,
  output logic [WAY_W-1:0] victimWay
);

  // age 0 = most recent, NUM_WAYS-1 = least recent
  logic [WAY_W-1:0] ageMem [NUM_SETS][NUM_WAYS];
  logic [WAY_W-1:0] touchAge;

  assign touchAge = ageMem[setIdx][touchWay];

  always_comb begin
    victimWay = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (ageMem[setIdx][w] == WAY_W'(NUM_WAYS - 1)) victimWay = WAY_W'(w);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          ageMem[s][w] <= WAY_W'(w);
        end
      end
    end else if (touchEn) begin
      for (int w = 0; w < NUM_WAYS; w++) begin
        if (WAY_W'(w) == touchWay)
          ageMem[setIdx][w] <= '0;
        else if (ageMem[setIdx][w] < touchAge)
          ageMem[setIdx][w] <= ageMem[setIdx][w] + 1'b1;
      end
    end
  end

endmodule

// File: rtl/sbaf_datapath.sv
module sbaf_datapath
  import sbaf_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS),
  localparam int TAG_W = ADDR_W - SB_OFF_W - SET_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reqAddr,
  input  sbafStrobe_t       stb,
  input  logic [WAY_W-1:0]  wrWay,
  output sbafLookup_t       lk,
  output logic [WAY_W-1:0]  matchWay,
  output logic [WAY_W-1:0]  freeWay,
  output logic [SET_W-1:0]  reqSet
);

  logic [TAG_W-1:0]     tagMem  [NUM_SETS][NUM_WAYS];
  logic [SB_BLOCKS-1:0] vldMem  [NUM_SETS][NUM_WAYS];
  logic [SB_BLOCKS-1:0] seenMem [NUM_SETS][NUM_WAYS];

  logic [SB_OFF_W-1:0]  reqBlk;
  logic [TAG_W-1:0]     reqTag;
  logic [SB_BLOCKS-1:0] blkMask;
  logic [NUM_WAYS-1:0]  matchVec;
  logic [NUM_WAYS-1:0]  freeVec;

  assign reqBlk  = reqAddr[SB_OFF_W-1:0];
  assign reqSet  = reqAddr[SB_OFF_W +: SET_W];
  assign reqTag  = reqAddr[ADDR_W-1 -: TAG_W];
  assign blkMask = SB_BLOCKS'(1) << reqBlk;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign matchVec[w] = (|vldMem[reqSet][w]) && (tagMem[reqSet][w] == reqTag);
    assign freeVec[w]  = ~|vldMem[reqSet][w];
  end

  always_comb begin
    matchWay = '0;
    freeWay  = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (matchVec[w]) matchWay = WAY_W'(w);
      if (freeVec[w])  freeWay  = WAY_W'(w);
    end
  end

  always_comb begin
    lk.sbPresent = |matchVec;
    lk.freeAny   = |freeVec;
    lk.blkValid  = |(vldMem[reqSet][matchWay] & blkMask);
    lk.blkSeen   = |(seenMem[reqSet][matchWay] & blkMask);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          tagMem[s][w]  <= '0;
          vldMem[s][w]  <= '0;
          seenMem[s][w] <= '0;
        end
      end
    end else if (stb.tagWrite) begin
      tagMem[reqSet][wrWay]  <= reqTag;
      vldMem[reqSet][wrWay]  <= blkMask;
      seenMem[reqSet][wrWay] <= '0;
    end else begin
      if (stb.validSet) vldMem[reqSet][wrWay] <= vldMem[reqSet][wrWay] | blkMask;
      if (stb.seenSet)
        seenMem[reqSet][wrWay] <= seenMem[reqSet][wrWay] | blkMask;
      else if (stb.seenClr)
        seenMem[reqSet][wrWay] <= seenMem[reqSet][wrWay] & ~blkMask;
    end
  end

endmodule

// File: rtl/sbaf_ctrl.sv
module sbaf_ctrl
  import sbaf_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reqUncomp,
  input  sbafLookup_t      lk,
  input  logic [WAY_W-1:0] matchWay,
  input  logic [WAY_W-1:0] freeWay,
  input  logic [WAY_W-1:0] lruWay,
  output sbafStrobe_t      stb,
  output logic [WAY_W-1:0] wrWay,
  output logic             rspValid,
  output logic             rspHit,
  output logic             rspAlloc,
  output logic             rspBypass,
  output logic [WAY_W-1:0] rspWay
);

  sbafOutcome_t outcome;

  always_comb begin
    if (!reqValid)
      outcome = OUT_NONE;
    else if (lk.sbPresent && lk.blkValid)
      outcome = OUT_HIT;
    else if (lk.sbPresent && reqUncomp && !lk.blkSeen)
      outcome = OUT_BYPASS;
    else
      outcome = OUT_ALLOC;
  end

  always_comb begin
    if (lk.sbPresent)    wrWay = matchWay;
    else if (lk.freeAny) wrWay = freeWay;
    else                 wrWay = lruWay;
  end

  always_comb begin
    stb.tagWrite = (outcome == OUT_ALLOC) && !lk.sbPresent;
    stb.validSet = (outcome == OUT_ALLOC) && lk.sbPresent;
    stb.seenClr  = (outcome == OUT_ALLOC) && lk.sbPresent;
    stb.seenSet  = (outcome == OUT_BYPASS);
    stb.lruTouch = (outcome == OUT_HIT) || (outcome == OUT_ALLOC);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid  <= 1'b0;
      rspHit    <= 1'b0;
      rspAlloc  <= 1'b0;
      rspBypass <= 1'b0;
      rspWay    <= '0;
    end else begin
      rspValid  <= (outcome != OUT_NONE);
      rspHit    <= (outcome == OUT_HIT);
      rspAlloc  <= (outcome == OUT_ALLOC);
      rspBypass <= (outcome == OUT_BYPASS);
      rspWay    <= (outcome == OUT_NONE) ? '0 : wrWay;
    end
  end

endmodule

// File: rtl/sb_alloc_filter.sv
module sb_alloc_filter
  import sbaf_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  localparam int WAY_W = $clog2(NUM_WAYS),
  localparam int SET_W = $clog2(NUM_SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              reqUncomp,
  output logic              rspValid,
  output logic              rspHit,
  output logic              rspAlloc,
  output logic              rspBypass,
  output logic [WAY_W-1:0]  rspWay
);

  sbafStrobe_t      stb;
  sbafLookup_t      lk;
  logic [WAY_W-1:0] matchWay;
  logic [WAY_W-1:0] freeWay;
  logic [WAY_W-1:0] lruWay;
  logic [WAY_W-1:0] wrWay;
  logic [SET_W-1:0] reqSet;

  sbaf_datapath #(
    .ADDR_W(ADDR_W), .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .reqAddr(reqAddr), .stb(stb), .wrWay(wrWay),
    .lk(lk), .matchWay(matchWay), .freeWay(freeWay), .reqSet(reqSet)
  );

  sbaf_lru #(
    .NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS)
  ) u_lru (
    .clk(clk), .rst_n(rst_n), .setIdx(reqSet), .touchEn(stb.lruTouch),
    .touchWay(wrWay), .victimWay(lruWay)
  );

  sbaf_ctrl #(
    .NUM_WAYS(NUM_WAYS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqUncomp(reqUncomp),
    .lk(lk), .matchWay(matchWay), .freeWay(freeWay), .lruWay(lruWay),
    .stb(stb), .wrWay(wrWay), .rspValid(rspValid), .rspHit(rspHit),
    .rspAlloc(rspAlloc), .rspBypass(rspBypass), .rspWay(rspWay)
  );

endmodule

// File: rtl/sb_alloc_filter_chk.sv
module sb_alloc_filter_chk #(
  parameter int ADDR_W   = 16,
  parameter int NUM_WAYS = 4,
  localparam int WAY_W = $clog2(NUM_WAYS)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic [ADDR_W-1:0] reqAddr,
  input logic              reqUncomp,
  input logic              rspValid,
  input logic              rspHit,
  input logic              rspAlloc,
  input logic              rspBypass,
  input logic [WAY_W-1:0]  rspWay
);

  assert_one_outcome_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rspValid |-> $countones({rspHit, rspAlloc, rspBypass}) == 1);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !rspValid |-> !(rspHit || rspAlloc || rspBypass));

  assert_req_response_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reqValid |=> rspValid);

  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !reqValid |=> !rspValid);

  assert_compressed_no_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && !reqUncomp) |=> !rspBypass);

  assert_reuse_allocates_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rspBypass && reqValid && reqUncomp && reqAddr == $past(reqAddr)) |=> rspAlloc);

  assert_alloc_then_hit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rspAlloc && reqValid && reqAddr == $past(reqAddr)) |=> (rspHit && rspWay == $past(rspWay)));

endmodule

bind sb_alloc_filter sb_alloc_filter_chk #(
  .ADDR_W(ADDR_W), .NUM_WAYS(NUM_WAYS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
  .reqUncomp(reqUncomp), .rspValid(rspValid), .rspHit(rspHit),
  .rspAlloc(rspAlloc), .rspBypass(rspBypass), .rspWay(rspWay)
);

// File: tb/test_sb_alloc_filter.sv
`timescale 1ns/1ps
module test_sb_alloc_filter;

  localparam int ADDR_W = 16;
  localparam int WW     = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reqValid = 1'b0;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic          reqUncomp = 1'b0;
  logic          rspValid, rspHit, rspAlloc, rspBypass;
  logic [WW-1:0] rspWay;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // expected item: {hit, alloc, bypass, way}
  logic [WW+2:0] expQ [$];
  string         tagQ [$];

  always #2.5 clk = ~clk;

  sb_alloc_filter i_sb_alloc_filter (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqUncomp(reqUncomp), .rspValid(rspValid), .rspHit(rspHit),
    .rspAlloc(rspAlloc), .rspBypass(rspBypass), .rspWay(rspWay)
  );

  function automatic logic [ADDR_W-1:0] mk(int tag, int set, int blk);
    return ADDR_W'((tag << 6) | (set << 2) | blk);
  endfunction

  localparam logic [2:0] HIT = 3'b100, ALLOC = 3'b010, BYP = 3'b001;

  task automatic doReq(input int tag, input int set, input int blk, input bit unc,
                       input logic [2:0] kind, input int way, input string req);
    @(negedge clk);
    reqValid  = 1'b1;
    reqAddr   = mk(tag, set, blk);
    reqUncomp = unc;
    expQ.push_back({kind, WW'(way)});
    tagQ.push_back(req);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      reqValid = 1'b0;
    end
  endtask

  // monitor: compare each response with the oldest expected item
  always @(negedge clk) begin
    if (rst_n && rspValid) begin
      checks++;
      if (expQ.size() == 0) begin
        failures++;
        $display("FAIL R10: response with no request, got hit=%0b alloc=%0b bypass=%0b expected none",
                 rspHit, rspAlloc, rspBypass);
      end else begin
        logic [WW+2:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if ({rspHit, rspAlloc, rspBypass, rspWay} !== e) begin
          failures++;
          $display("FAIL %s: got hit=%0b alloc=%0b bypass=%0b way=%0d expected hit=%0b alloc=%0b bypass=%0b way=%0d",
                   t, rspHit, rspAlloc, rspBypass, rspWay, e[WW+2], e[WW+1], e[WW], e[WW-1:0]);
        end
      end
    end
  end

  task automatic checkQuiet(input string req);
    checks++;
    if (rspValid !== 1'b0 || rspHit !== 1'b0 || rspAlloc !== 1'b0 || rspBypass !== 1'b0) begin
      failures++;
      $display("FAIL %s: got valid=%0b hit=%0b alloc=%0b bypass=%0b expected all 0",
               req, rspValid, rspHit, rspAlloc, rspBypass);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checkQuiet("R9 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    checkQuiet("R9 after reset");

    // set 0, super-block tag 1
    doReq(1, 0, 0, 1, ALLOC, 0, "R9 R3 first fill uses way 0");
    doReq(1, 0, 0, 1, HIT,   0, "R1 hit on resident block");
    doReq(1, 0, 1, 1, BYP,   0, "R4 first use of sibling bypassed");
    doReq(1, 0, 1, 1, ALLOC, 0, "R5 first reuse allocates");
    doReq(1, 0, 1, 1, HIT,   0, "R5 hit after reuse allocation");
    doReq(1, 0, 2, 0, ALLOC, 0, "R6 compressed sibling allocates");
    doReq(1, 0, 3, 1, BYP,   0, "R4 sibling block 3 bypassed");
    idle(2);
    checkQuiet("R10 no response while idle");
    doReq(1, 0, 2, 1, HIT,   0, "R4 bypass leaves other blocks");
    // fill remaining ways
    doReq(2, 0, 0, 1, ALLOC, 1, "R3 lowest free way 1");
    doReq(3, 0, 0, 1, ALLOC, 2, "R3 lowest free way 2");
    doReq(4, 0, 0, 1, ALLOC, 3, "R3 lowest free way 3");
    doReq(1, 0, 3, 1, ALLOC, 0, "R5 seen bit survives other traffic");
    doReq(3, 0, 0, 1, HIT,   2, "R8 hit refreshes way 2");
    doReq(2, 0, 1, 1, BYP,   1, "R4 bypass in way 1");
    doReq(5, 0, 0, 1, ALLOC, 1, "R8 bypass did not refresh, victim way 1");
    doReq(2, 0, 0, 1, ALLOC, 3, "R8 LRU victim way 3");
    doReq(2, 0, 1, 1, BYP,   3, "R7 eviction dropped seen bit");
    doReq(4, 0, 0, 1, ALLOC, 0, "R8 LRU victim way 0");
    doReq(1, 0, 0, 1, ALLOC, 2, "R8 LRU victim way 2");
    doReq(1, 0, 1, 1, BYP,   2, "R7 reinstalled super-block forgets block 1");
    doReq(1, 0, 1, 1, ALLOC, 2, "R5 reuse after reinstall");
    // independent set
    doReq(7, 5, 2, 0, ALLOC, 0, "R8 other set starts empty");
    doReq(7, 5, 2, 0, HIT,   0, "R1 hit in set 5");
    doReq(7, 5, 0, 0, ALLOC, 0, "R6 compressed never bypassed");
    doReq(1, 0, 1, 0, HIT,   2, "R1 set 0 intact after set 5 traffic");
    idle(4);
    checkQuiet("R10 idle after traffic");
    checks++;
    if (expQ.size() != 0) begin
      failures++;
      $display("FAIL R10: got %0d responses missing expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule